// File: doc/BRIEF.md
# Interrupt Enable and Pending Status Register

This block is one byte-wide register that controls a small set of edge-triggered interrupt sources. Writing the register sets the enable mask. Reading it returns the set of enabled sources that have seen an event and are still pending. A single interrupt request output is high while anything is pending.

A source becomes pending on a rising edge of its input, and only while that source is enabled. Software acknowledges an interrupt by writing the enable bit to 0, which clears the pending bit. Writing the bit back to 1 arms the source for its next edge. A parameter fixes which source positions exist. A bit outside that set, or above the source count, can never be enabled, never becomes pending and always reads as 0.

Top module: `irq_sense_reg`

## Requirements
- R1: While rst_ni is low, and after it is released, the enable mask and all pending bits are 0, so rdata_o reads 8'h00 and irq_o is 0. A source edge after reset sets nothing until an enable is written.
- R2: When wr_en_i is high at a clock edge, wdata_i bit i becomes the enable of source i, for i from 0 to 5. Pending bit i appears at rdata_o bit i.
- R3: rdata_o bits 7:6, and every bit that is 0 in VALID_MASK, always read 0, whatever value is written or driven on the source inputs. The default VALID_MASK is 6'b110111.
- R4: A rising edge on a disabled source never sets its pending bit.
- R5: Writing 0 to an enable bit clears that source's pending bit at the same clock edge.
- R6: irq_o is 1 exactly when rdata_o is non-zero.
- R7: Once an acknowledged source is enabled again, a new rising edge on it sets its pending bit one clock later.
- R8: Pending bits are set by edges, not levels. Re-enabling a source whose input is held high does not make it pending.
- R9: At an edge where a write changes the enable, a rising edge on the source counts only if the source was enabled both before and after the write. Enabling and disabling in that same cycle both leave the bit clear.
- R10: A pending bit stays set until a write clears its enable. Writes that keep the bit enabled, and edges on other sources, leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the enable mask |
| wdata_i | input | 8 | Write data, bit i enables source i |
| src_i | input | 6 | Event source levels, rising-edge sensitive |
| rdata_o | output | 8 | Enabled pending status, masked by VALID_MASK |
| irq_o | output | 1 | Interrupt request, high while any status bit is set |

## Verification
A software write to the enable mask and a rising edge on the same source can land in the same clock. The enable write is either an acknowledgement that clears the source or a re-arm that sets it. The bench places an edge on the source in exactly the cycle of each kind of write. It then reads the status one cycle later and expects the bit to be clear in both cases. A following vector shows that a later edge, with the source enabled both before and after, is still captured.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  localparam int unsigned IRQ_SRC_N = 6;
  localparam int unsigned IRQ_BUS_W = 8;
  localparam logic [IRQ_SRC_N-1:0] IRQ_VALID_DEF = 6'b110111;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic lvl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q <= 1'b0;
      else         lvl_q <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~lvl_q;
  end
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int unsigned N      = 6,
  parameter int unsigned BUS_W  = 8,
  parameter logic [N-1:0] VALID = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [N-1:0]     en_q_o,
  output logic [N-1:0]     en_d_o
);
  logic [BUS_W-1:0] unused_wdata;
  assign unused_wdata = wdata_i;

  // invalid positions can never hold an enable
  assign en_d_o = wr_en_i ? (wdata_i[N-1:0] & VALID) : en_q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q_o <= '0;
    else         en_q_o <= en_d_o;
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] en_q_i,
  input  logic [N-1:0] en_d_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_cell
    logic set_c;
    // edge counts only with the source enabled before and after this edge
    assign set_c = rise_i[g] & en_q_i[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o[g] <= 1'b0;
      else         pend_o[g] <= (pend_o[g] | set_c) & en_d_i[g];
    end
  end
endmodule

// File: rtl/irq_status_view.sv
module irq_status_view #(
  parameter int unsigned N      = 6,
  parameter int unsigned BUS_W  = 8,
  parameter logic [N-1:0] VALID = '1
) (
  input  logic [N-1:0]     pend_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             irq_o
);
  localparam logic [BUS_W-1:0] VALID_EXT = BUS_W'(VALID);
  logic [BUS_W-1:0] pend_ext;

  assign pend_ext = BUS_W'(pend_i);
  assign rdata_o  = pend_ext & VALID_EXT;
  assign irq_o    = |rdata_o;
endmodule

// File: rtl/irq_sense_reg.sv
module irq_sense_reg
  import irq_sense_pkg::*;
#(
  parameter int unsigned NUM_SRC          = IRQ_SRC_N,
  parameter int unsigned BUS_W            = IRQ_BUS_W,
  parameter logic [NUM_SRC-1:0] VALID_MASK = IRQ_VALID_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [BUS_W-1:0]   wdata_i,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [BUS_W-1:0]   rdata_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] rise, en_q, en_d, pend;

  irq_edge_det #(.N(NUM_SRC)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (src_i),
    .rise_o (rise)
  );

  irq_en_reg #(.N(NUM_SRC), .BUS_W(BUS_W), .VALID(VALID_MASK)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .en_q_o  (en_q),
    .en_d_o  (en_d)
  );

  irq_pend_bank #(.N(NUM_SRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .en_q_i (en_q),
    .en_d_i (en_d),
    .pend_o (pend)
  );

  irq_status_view #(.N(NUM_SRC), .BUS_W(BUS_W), .VALID(VALID_MASK)) u_view (
    .pend_i  (pend),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/irq_sense_reg_chk.sv
module irq_sense_reg_chk #(
  parameter int unsigned NUM_SRC          = 6,
  parameter int unsigned BUS_W            = 8,
  parameter logic [NUM_SRC-1:0] VALID_MASK = '1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [BUS_W-1:0]   wdata_i,
  input logic [NUM_SRC-1:0] src_i,
  input logic [BUS_W-1:0]   rdata_o,
  input logic               irq_o
);
  localparam logic [BUS_W-1:0] VALID_EXT = BUS_W'(VALID_MASK);

  logic [NUM_SRC-1:0] src_d, src_dd;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_d  <= '0;
      src_dd <= '0;
    end else begin
      src_d  <= src_i;
      src_dd <= src_d;
    end
  end

  logic [BUS_W-1:0] rose_ext;
  assign rose_ext = BUS_W'(src_d & ~src_dd);

  // R1
  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (rdata_o == '0 && !irq_o));

  a_r3_invalid_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~VALID_EXT) == '0);

  a_r4_set_needs_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdata_o & ~$past(rdata_o)) & ~rose_ext) == '0);

  a_r5_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rdata_o[NUM_SRC-1:0] & ~$past(wdata_i[NUM_SRC-1:0])) == '0);

  a_r6_irq_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (rdata_o != '0));

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($past(rdata_o) & ~rdata_o) == '0);
endmodule

bind irq_sense_reg irq_sense_reg_chk #(
  .NUM_SRC(NUM_SRC), .BUS_W(BUS_W), .VALID_MASK(VALID_MASK)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .wdata_i (wdata_i),
  .src_i   (src_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o)
);

// File: tb/sim_irq_sense_reg.sv
`timescale 1ns/1ps
module sim_irq_sense_reg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [5:0] src_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  irq_sense_reg u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
    .src_i(src_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // {wr, wdata[7:0], src[5:0], exp_rdata[7:0], req[3:0]}; VALID_MASK = 6'b110111
  localparam int NV = 20;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 8'hFF, 6'b000000, 8'h00, 4'd2},  // R2 enable all valid
    {1'b0, 8'h00, 6'b000001, 8'h01, 4'd2},  // R2 edge on source 0
    {1'b0, 8'h00, 6'b001001, 8'h01, 4'd3},  // R3 invalid source 3
    {1'b0, 8'h00, 6'b001001, 8'h01, 4'd8},  // R8 held level
    {1'b1, 8'hFE, 6'b001001, 8'h00, 4'd5},  // R5 acknowledge source 0
    {1'b1, 8'hFF, 6'b001001, 8'h00, 4'd8},  // R8 re-enable while high
    {1'b0, 8'h00, 6'b000000, 8'h00, 4'd8},
    {1'b0, 8'h00, 6'b000001, 8'h01, 4'd7},  // R7 rearmed
    {1'b0, 8'h00, 6'b100001, 8'h21, 4'd10}, // R10 second source
    {1'b1, 8'h20, 6'b100001, 8'h20, 4'd10}, // R10 kept bit survives write
    {1'b0, 8'h00, 6'b000000, 8'h20, 4'd10},
    {1'b0, 8'h00, 6'b000010, 8'h20, 4'd4},  // R4 disabled source 1
    {1'b1, 8'h00, 6'b000010, 8'h00, 4'd5},
    {1'b0, 8'h00, 6'b000000, 8'h00, 4'd5},
    {1'b1, 8'h02, 6'b000010, 8'h00, 4'd9},  // R9 enable with edge
    {1'b0, 8'h00, 6'b000000, 8'h00, 4'd9},
    {1'b1, 8'h00, 6'b000010, 8'h00, 4'd9},  // R9 disable with edge
    {1'b1, 8'h02, 6'b000000, 8'h00, 4'd9},
    {1'b0, 8'h00, 6'b000010, 8'h02, 4'd9},  // R9 plain edge captured
    {1'b1, 8'hC2, 6'b000010, 8'h02, 4'd3}   // R3 upper bits written
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #5;
    check("R1", rdata_o, 8'h00);
    check("R1", {7'd0, irq_o}, 8'h00);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    check("R1", rdata_o, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr_en_i = VEC[i][26];
      wdata_i = VEC[i][25:18];
      src_i   = VEC[i][17:12];
      step();
      check($sformatf("R%0d vec%0d", VEC[i][3:0], i), rdata_o, VEC[i][11:4]);
      check($sformatf("R6 vec%0d", i), {7'd0, irq_o}, {7'd0, VEC[i][11:4] != 8'h00});
    end
    wr_en_i = 1'b0;

    // R3: invalid-only enable and edge, bit 3 never shows
    wr_en_i = 1'b1; wdata_i = 8'h08; src_i = 6'b000000; step();
    wr_en_i = 1'b0; src_i = 6'b001000; step();
    check("R3 invalid only", rdata_o, 8'h00);
    check("R6 idle", {7'd0, irq_o}, 8'h00);

    // R1: reset mid-run clears pending and enable
    wr_en_i = 1'b1; wdata_i = 8'h10; src_i = 6'b000000; step();
    wr_en_i = 1'b0; src_i = 6'b010000; step();
    check("R10 pre-reset", rdata_o, 8'h10);
    rst_ni = 1'b0; #1;
    check("R1 async", rdata_o, 8'h00);
    check("R1 async irq", {7'd0, irq_o}, 8'h00);
    step();
    rst_ni = 1'b1; src_i = 6'b000000; step();
    src_i = 6'b010000; step();
    check("R1 enable cleared", rdata_o, 8'h00);

    // R2: several sources in one edge
    wr_en_i = 1'b1; wdata_i = 8'h33; src_i = 6'b000000; step();
    wr_en_i = 1'b0; src_i = 6'b110011; step();
    check("R2 multi", rdata_o, 8'h33);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule